// File: doc/BRIEF.md
# Block Cipher Host Buffering Interface

This block sits between a 32-bit host register bus and a 64-bit block cipher engine. The host loads a mode word, three 64-bit key slots and a 64-bit chaining vector. It then feeds blocks as two 32-bit halves. Writing the left half commits the block, and the engine is started with no separate command. The engine is reached through a one-cycle start pulse and a one-cycle done pulse. The cipher itself lives outside this block.

Finished results first sit in a hidden holding stage. They move into the host-visible output register once the previous output has been consumed. The host reads the right half first, and reading the left half consumes the block. The block tracks how many blocks are outstanding. With two results unread it stops launching the engine. With a third block waiting it drops the input-ready flag, and a further block overwrites that waiting one. In chaining mode the vector is mixed in around the engine and updated after every block. The vector can be read back, so a context can be saved and restored.

Top module: `blkcip_hostbuf`

Address map (word addresses): 0 mode (bit0 decrypt, bit1 triple-key, bit2 chaining), 1 status, 2/3 key slot 1 right/left, 4/5 key slot 2, 6/7 key slot 3, 8/9 vector right/left, 10/11 input right/left, 12/13 output right/left. A 64-bit value is {left, right}.

## Requirements
- R1: After reset all data and context registers read zero, and status (bit0 busy, bit1 input-ready, bit2 output-ready, bit3 error) reads 0x2. The engine is idle and irq is low.
- R2: A write to address 11 commits {written word, last word written to address 10} as one block. With the engine idle and the holding stage empty, eng_start pulses for one cycle carrying that block.
- R3: The host reads output right (12) then left (13). The address-13 read consumes the block, and results come out in commit order.
- R4: A result that finishes while the output is unread waits in the holding stage. It is copied into the output on the consuming read, with output-ready staying high. Output data does not change while it is unread.
- R5: irq equals the output-ready flag at all times.
- R6: While the holding stage is full (two results unread), the engine is not started.
- R7: Input-ready is low while a committed block waits unlaunched, so it reads low with three blocks outstanding. A fourth block replaces the third, which is lost.
- R8: Key outputs to the engine have bits 0, 8, 16 ... 56 forced to zero. In single-key mode only slot 1 reaches the engine and slots 2 and 3 read as zero on its ports.
- R9: In chaining encrypt mode the engine receives block XOR vector, and the vector then takes the engine result, which is also the output.
- R10: In chaining decrypt mode the output is engine result XOR vector, and the vector then takes the incoming block.
- R11: The vector registers read back the updated vector after each chained block.
- R12: A write to a key or vector register while busy sets the sticky error bit (status bit3), and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe (side effects only) |
| rd_addr | input | 4 | Host read word address |
| rd_data | output | 32 | Host read data (combinational) |
| in_rdy | output | 1 | Input-ready flag |
| out_rdy | output | 1 | Output-ready flag |
| irq | output | 1 | Interrupt, follows output-ready |
| eng_start | output | 1 | One-cycle engine start |
| eng_din | output | 64 | Block to the engine |
| eng_decrypt | output | 1 | Engine direction |
| eng_triple | output | 1 | Engine triple-key mode |
| eng_key1 | output | 64 | Key slot 1, parity cleared |
| eng_key2 | output | 64 | Key slot 2, parity cleared |
| eng_key3 | output | 64 | Key slot 3, parity cleared |
| eng_done | input | 1 | One-cycle engine completion |
| eng_dout | input | 64 | Engine result |

## Verification
The assertions take for granted that the engine answers every start with exactly one done pulse. That pulse comes at least one cycle later and never while the engine is idle. The output-right read is assumed to come before the consuming left read. The bench stand-in engine latches its input on start and returns a reversible rotate-and-XOR of it after a fixed five-cycle delay. The bench reader always reads address 12 before 13, and it touches the output only while output-ready is set.

// File: rtl/blkcip_hostbuf.sv
module blkcip_hostbuf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        in_rdy,
  output logic        out_rdy,
  output logic        irq,
  output logic        eng_start,
  output logic [63:0] eng_din,
  output logic        eng_decrypt,
  output logic        eng_triple,
  output logic [63:0] eng_key1,
  output logic [63:0] eng_key2,
  output logic [63:0] eng_key3,
  input  logic        eng_done,
  input  logic [63:0] eng_dout
);
  localparam logic [63:0] PAR_MASK = 64'hFEFE_FEFE_FEFE_FEFE;

  logic [2:0]  mode;
  logic [63:0] key1, key2, key3, iv, pend, ct_save, hold, dout, din_q;
  logic [31:0] din_r;
  logic        pend_v, busy, hold_v, out_v, err, start_q;

  wire dec   = mode[0];
  wire chain = mode[2];
  wire commit  = wr_en && wr_addr == 4'd11;
  wire consume = rd_en && rd_addr == 4'd13 && out_v;
  wire ctx_wr  = wr_en && wr_addr >= 4'd2 && wr_addr <= 4'd9;
  wire launch  = pend_v && !busy && !hold_v;
  wire xfer    = hold_v && (!out_v || consume);
  wire done    = eng_done && busy;

  assign in_rdy      = !pend_v;
  assign out_rdy     = out_v;
  assign irq         = out_v;
  assign eng_start   = start_q;
  assign eng_din     = din_q;
  assign eng_decrypt = dec;
  assign eng_triple  = mode[1];
  assign eng_key1    = key1 & PAR_MASK;
  assign eng_key2    = mode[1] ? (key2 & PAR_MASK) : 64'd0;
  assign eng_key3    = mode[1] ? (key3 & PAR_MASK) : 64'd0;

  always_comb begin
    case (rd_addr)
      4'd0:    rd_data = {29'd0, mode};
      4'd1:    rd_data = {28'd0, err, out_v, in_rdy, busy};
      4'd2:    rd_data = key1[31:0];
      4'd3:    rd_data = key1[63:32];
      4'd4:    rd_data = key2[31:0];
      4'd5:    rd_data = key2[63:32];
      4'd6:    rd_data = key3[31:0];
      4'd7:    rd_data = key3[63:32];
      4'd8:    rd_data = iv[31:0];
      4'd9:    rd_data = iv[63:32];
      4'd10:   rd_data = din_r;
      4'd11:   rd_data = pend[63:32];
      4'd12:   rd_data = dout[31:0];
      4'd13:   rd_data = dout[63:32];
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; key1 <= '0; key2 <= '0; key3 <= '0; iv <= '0;
      pend <= '0; ct_save <= '0; hold <= '0; dout <= '0; din_q <= '0;
      din_r <= '0; pend_v <= 1'b0; busy <= 1'b0; hold_v <= 1'b0;
      out_v <= 1'b0; err <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy    <= 1'b1;
        din_q   <= (chain && !dec) ? pend ^ iv : pend;
        ct_save <= pend;
      end
      if (commit) begin
        pend   <= {wr_data, din_r};
        pend_v <= 1'b1;
      end else if (launch) begin
        pend_v <= 1'b0;
      end
      if (xfer) begin
        dout   <= hold;
        out_v  <= 1'b1;
        hold_v <= 1'b0;
      end else if (consume) begin
        out_v <= 1'b0;
      end
      if (done) begin
        busy   <= 1'b0;
        hold_v <= 1'b1;
        hold   <= (chain && dec) ? eng_dout ^ iv : eng_dout;
        if (chain) iv <= dec ? ct_save : eng_dout;
      end
      if (ctx_wr && busy) err <= 1'b1;
      if (wr_en) begin
        case (wr_addr)
          4'd0:  mode          <= wr_data[2:0];
          4'd2:  key1[31:0]    <= wr_data;
          4'd3:  key1[63:32]   <= wr_data;
          4'd4:  key2[31:0]    <= wr_data;
          4'd5:  key2[63:32]   <= wr_data;
          4'd6:  key3[31:0]    <= wr_data;
          4'd7:  key3[63:32]   <= wr_data;
          4'd8:  iv[31:0]      <= wr_data;
          4'd9:  iv[63:32]     <= wr_data;
          4'd10: din_r         <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R2
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pend_v || busy));
  // R3
  out_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !consume) |=> out_v);
  // R4
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !consume) |=> $stable(dout));
  // R6
  no_start_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> !eng_start);
  // R7
  inrdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && hold_v && out_v) |-> !in_rdy);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/test_blkcip_hostbuf.sv
module test_blkcip_hostbuf;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic in_rdy, out_rdy, irq, eng_start, eng_decrypt, eng_triple, eng_done;
  logic [63:0] eng_din, eng_key1, eng_key2, eng_key3, eng_dout;

  int checks = 0, fails = 0;
  bit mon_en = 0;
  logic [63:0] exp_q[$];
  localparam logic [63:0] PM = 64'hFEFE_FEFE_FEFE_FEFE;

  always #10 clk = ~clk;

  blkcip_hostbuf i_blkcip_hostbuf (.*);

  // stand-in engine, five-cycle latency
  logic [63:0] e_buf; int e_cnt = 0;
  always_ff @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      e_cnt <= 5;
      e_buf <= eng_decrypt ? ror8(eng_din ^ eng_key1 ^ eng_key2 ^ eng_key3)
                           : rol8(eng_din) ^ eng_key1 ^ eng_key2 ^ eng_key3;
    end else if (e_cnt > 0) begin
      e_cnt <= e_cnt - 1;
      if (e_cnt == 1) begin eng_done <= 1'b1; eng_dout <= e_buf; end
    end
  end

  function automatic logic [63:0] rol8(logic [63:0] x); return {x[55:0], x[63:56]}; endfunction
  function automatic logic [63:0] ror8(logic [63:0] x); return {x[7:0], x[63:8]}; endfunction

  logic [63:0] k1, k2, k3, miv; bit m_tri;
  function automatic logic [63:0] ks();
    return (k1 & PM) ^ (m_tri ? ((k2 & PM) ^ (k3 & PM)) : 64'd0);
  endfunction
  function automatic logic [63:0] enc(logic [63:0] p); return rol8(p) ^ ks(); endfunction
  function automatic logic [63:0] dcr(logic [63:0] c); return ror8(c ^ ks()); endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic wr64(logic [3:0] a, logic [63:0] v);
    wr(a, v[31:0]); wr(a + 4'd1, v[63:32]);
  endtask
  task automatic rd64(logic [3:0] a, output logic [63:0] v);
    logic [31:0] lo, hi; rd(a, lo); rd(a + 4'd1, hi); v = {hi, lo};
  endtask
  task automatic send(logic [63:0] p, bit push, logic [63:0] e);
    if (push) exp_q.push_back(e);
    wr64(4'd10, p);
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic drain();
    mon_en = 1; idle(60);
    mon_en = 0; idle(4);
    chk("R3 queue empty", exp_q.size(), 0);
  endtask

  // monitor: pops expected results in order (R3, R4)
  initial forever begin
    logic [31:0] lo, hi;
    @(negedge clk);
    if (mon_en && out_rdy) begin
      rd(4'd12, lo); rd(4'd13, hi);
      if (exp_q.size() == 0) chk("R3 unexpected output", {hi, lo}, 64'hx);
      else chk("R3/R4 output data", {hi, lo}, exp_q.pop_front());
    end
  end

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [63:0] v, c1, c2, p1, p2;
    k1 = 0; k2 = 0; k3 = 0; m_tri = 0; miv = 0;
    idle(3); rst_n = 1; idle(2);
    // R1
    rd(4'd1, d); chk("R1 status", d, 32'h2);
    rd64(4'd2, v); chk("R1 key1", v, 0);
    rd64(4'd12, v); chk("R1 dout", v, 0);
    chk("R1 irq", irq, 0);
    // R8 single mode, parity bits present
    k1 = 64'h0123_4567_89AB_CDEF; k2 = 64'h1111_2222_3333_4444; k3 = 64'h5555_6666_7777_8888;
    wr64(4'd2, k1); wr64(4'd4, k2); wr64(4'd6, k3);
    idle(1);
    chk("R8 key1 parity cleared", eng_key1, k1 & PM);
    chk("R8 key2 zero in single", eng_key2, 0);
    // R2 commit starts engine
    mon_en = 0;
    fork
      send(64'hA5A5_0000_1234_5678, 1, enc(64'hA5A5_0000_1234_5678));
      begin @(posedge eng_start); #1 chk("R2 start data", eng_din, 64'hA5A5_0000_1234_5678); end
    join
    drain();
    // R3 several blocks with the monitor running
    mon_en = 1;
    for (int i = 0; i < 4; i++) begin
      send(64'h1000_0000_0000_0001 * (i + 3), 1, enc(64'h1000_0000_0000_0001 * (i + 3))); idle(12);
    end
    drain();
    // R4 R5 R6 R7: three outstanding
    send(64'hAAAA_0001, 1, enc(64'hAAAA_0001)); idle(15);
    send(64'hAAAA_0002, 1, enc(64'hAAAA_0002)); idle(15);
    send(64'hAAAA_0003, 1, enc(64'hAAAA_0003)); idle(15);
    rd(4'd1, d); chk("R7 status three outstanding", d, 32'h4);
    chk("R7 in_rdy low", in_rdy, 0);
    chk("R5 irq follows out_rdy", irq, 1);
    chk("R6 engine stalled", i_blkcip_hostbuf.eng_start, 0);
    drain();
    rd(4'd1, d); chk("R4 status after drain", d, 32'h2);
    chk("R5 irq low", irq, 0);
    // R7 fourth block overwrites third
    send(64'hBBBB_0001, 1, enc(64'hBBBB_0001)); idle(15);
    send(64'hBBBB_0002, 1, enc(64'hBBBB_0002)); idle(15);
    send(64'hBBBB_0003, 0, 0); idle(15);
    send(64'hBBBB_0004, 1, enc(64'hBBBB_0004)); idle(15);
    drain();
    // R8 triple mode
    m_tri = 1; wr(4'd0, 32'h2); idle(1);
    chk("R8 key3 triple", eng_key3, k3 & PM);
    send(64'hDEAD_BEEF_0BAD_F00D, 1, enc(64'hDEAD_BEEF_0BAD_F00D));
    drain();
    // R9 R11 chained encrypt
    miv = 64'h0F0F_1234_5678_9ABC; wr64(4'd8, miv); wr(4'd0, 32'h6);
    p1 = 64'h1111_0000_2222_0000; p2 = 64'h3333_0000_4444_0000;
    c1 = enc(p1 ^ miv); c2 = enc(p2 ^ c1);
    send(p1, 1, c1); idle(12); send(p2, 1, c2);
    drain();
    rd64(4'd8, v); chk("R11 vector after encrypt", v, c2);
    // R10 chained decrypt
    wr64(4'd8, miv); wr(4'd0, 32'h7);
    send(c1, 1, p1); idle(12); send(c2, 1, p2);
    drain();
    rd64(4'd8, v); chk("R10 vector after decrypt", v, c2);
    // R12 context write while busy
    m_tri = 0; wr(4'd0, 32'h0);
    send(64'h7777, 1, enc(64'h7777)); idle(1);
    wr(4'd7, 32'hCAFE_0001);
    rd(4'd1, d); chk("R12 error bit", d[3], 1);
    rd(4'd7, d); chk("R12 write applied", d, 32'hCAFE_0001);
    drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule